// File: doc/BRIEF.md
# Sensor-Bus Slave Transaction Engine

This block is the message layer of a slave on a single-wire, pulse-duration-coded sensor bus. A bit classifier in front of it turns each low pulse on the wire into a symbol: data 0, data 1, start, attention or bus reset. The engine follows the message that starts with each start symbol. It matches the device address against its strapped address or against broadcast address 0, and it collects a register address. It then either takes write data in or shifts read data out. It produces or checks even parity and handles the acknowledge slot. For the slots the slave owns, it tells an open-drain transmitter which data value to stretch the master's pulse into. The classifier then reports what the wire really carried, and the engine compares that against what it drove.

A failed read acknowledge, or a slave-owned slot whose observed symbol differs from the driven one, sets a sticky bus error flag and marks an attention request as pending. The attention pulse goes out only once the classifier reports an idle bus. A register-file port outside the block holds the storage: it gives a combinational read data bus and one-cycle read and write strobes.

Top module: `spb_slave_engine`

## Requirements
- R1: After `rst_n` is released, `tx_en`, `tx_attn`, `reg_we`, `reg_re`, `ber` and `attn_pend` are all 0.
- R2: Symbols use `sym_kind` codes 0 = data 0, 1 = data 1, 2 = start, 3 = attention, 4 = bus reset, and `sym_valid` qualifies them. After a start, a message carries, in this order: a 3-bit device address (MSB first), one R/W bit (1 = read, 0 = write), a 6-bit register address (MSB first), the data field, one parity bit, and one acknowledge slot.
- R3: The data field is 16 bits when bit `reg_addr` of `WIDE_MAP` is 1 and 8 bits otherwise, sent MSB first. A narrow write is zero-extended on `reg_wdata`, and a narrow read sends `reg_rdata[7:0]`.
- R4: A write to the own address with even parity causes the slave to drive the acknowledge slot as data 1. Once that slot is observed as data 1, `reg_we` pulses for one cycle with the received address and data.
- R5: A write to the own address with odd parity gets a data-0 acknowledge. It produces no write and no bus error.
- R6: A read from the own address pulses `reg_re` once after the last register-address bit. The slave then drives every data slot and the parity slot. The parity value makes the total count of ones even over the address, R/W, register-address and data bits. A data-1 acknowledge from the master ends the read with no error.
- R7: A data-0 or attention symbol in the acknowledge slot of a read sets `ber` and `attn_pend`, and so does a mismatch or attention symbol in any slot the slave drives. The message is then dropped.
- R8: Device address 0 is a broadcast. A broadcast read is ignored, with no drive and no `reg_re`. A broadcast write is committed after the parity slot if the parity is even, and its acknowledge slot is never driven.
- R9: A message for any other nonzero device address causes no drive and no strobe.
- R10: A start symbol in the middle of a message abandons it and begins a new one. It raises neither `ber` nor an attention request.
- R11: A bus reset symbol returns the engine to training and clears a pending attention request. The next eight data-0 symbols are consumed as training, and no data symbol is decoded as a message until a start arrives.
- R12: `tx_attn` pulses for exactly one cycle, only when `bus_idle` was high the cycle before, and then clears `attn_pend`.
- R13: The engine has no timeout. Gaps of any length, and attention symbols in master-driven slots, leave the message in progress intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| my_dev | input | 3 | Strapped device address (1 to 7) |
| sym_valid | input | 1 | One-cycle strobe for a classified symbol |
| sym_kind | input | 3 | Symbol code (see R2) |
| bus_idle | input | 1 | Classifier reports the wire idle |
| tx_en | output | 1 | Slave owns the current slot |
| tx_bit | output | 1 | Value to stretch the current slot into |
| tx_attn | output | 1 | One-cycle request to send an attention pulse |
| reg_addr | output | 6 | Register address of the current message |
| reg_wdata | output | 16 | Write data, zero-extended for narrow registers |
| reg_rdata | input | 16 | Combinational read data from the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| ber | output | 1 | Sticky bus error flag |
| attn_pend | output | 1 | Attention request waiting for an idle bus |

## Verification
A wrong state in this engine shows up at the ports within one symbol. A miscounted field moves the turn of `tx_en`, which corrupts the read value or parity the master assembles, or loses the acknowledge on a write. A wrong address latch lands `reg_we` on the wrong register, or lets a foreign or broadcast read drive the wire. Error handling is visible one cycle after the offending symbol through `ber` and `attn_pend`, and through the `tx_attn` pulse once `bus_idle` rises.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic [2:0] {
    SYM_D0    = 3'd0,
    SYM_D1    = 3'd1,
    SYM_START = 3'd2,
    SYM_ATTN  = 3'd3,
    SYM_RESET = 3'd4
  } sym_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_DEV,
    ST_RW,
    ST_IADDR,
    ST_FETCH,
    ST_DATA,
    ST_PAR,
    ST_ACK,
    ST_IGN
  } st_e;

  // running even-parity fold: the parity bit to send equals the fold
  function automatic logic fold_par(input logic acc, input logic b);
    return acc ^ b;
  endfunction

  // index of the last data slot for the chosen width
  function automatic int unsigned last_slot(input logic wide, input int unsigned dw,
                                            input int unsigned nw);
    return wide ? dw - 1 : nw - 1;
  endfunction

endpackage

// File: rtl/spb_addr_match.sv
module spb_addr_match #(
  parameter int DEV_W = 3
) (
  input  logic [DEV_W-1:0] dev_field,
  input  logic [DEV_W-1:0] my_dev,
  output logic             hit,
  output logic             bcast
);
  assign bcast = (dev_field == '0);
  assign hit   = !bcast && (dev_field == my_dev);
endmodule

// File: rtl/spb_shifter.sv
module spb_shifter #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         in_bit,
  input  logic         wide,
  output logic [W-1:0] q,
  output logic         msb
);
  localparam int PAD = W - NW;

  logic [W-1:0] r;

  always_ff @(posedge clk) begin
    if (!rst_n)      r <= '0;
    else if (clear)  r <= '0;
    else if (load)   r <= wide ? load_val : {{PAD{1'b0}}, load_val[NW-1:0]};
    else if (shift)  r <= {r[W-2:0], in_bit};
  end

  assign q   = r;
  assign msb = wide ? r[W-1] : r[NW-1];
endmodule

// File: rtl/spb_attn_ctl.sv
module spb_attn_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic drop,
  input  logic bus_idle,
  output logic ber,
  output logic pend,
  output logic fire
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ber  <= 1'b0;
      pend <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (raise) ber <= 1'b1;
      if (drop) begin
        pend <= 1'b0;
      end else if (raise) begin
        pend <= 1'b1;
      end else if (pend && bus_idle) begin
        pend <= 1'b0;
        fire <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spb_slave_engine.sv
module spb_slave_engine
  import spb_pkg::*;
#(
  parameter int DEV_W     = 3,
  parameter int IA_W      = 6,
  parameter int DATA_W    = 16,
  parameter int NARROW_W  = 8,
  parameter int TRAIN_LEN = 8,
  parameter logic [(1<<IA_W)-1:0] WIDE_MAP = 64'hF0F0_0000_3C00_00A6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  my_dev,
  input  logic              sym_valid,
  input  logic [2:0]        sym_kind,
  input  logic              bus_idle,
  output logic              tx_en,
  output logic              tx_bit,
  output logic              tx_attn,
  output logic [IA_W-1:0]   reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              ber,
  output logic              attn_pend
);
  localparam int CNT_MAX = (DATA_W > TRAIN_LEN) ? DATA_W : TRAIN_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PAD     = DATA_W - NARROW_W;

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [DEV_W-1:0]  dev_q;
  logic              rw_q;
  logic [IA_W-1:0]   ia_q;
  logic [IA_W-1:0]   ia_next;
  logic              par_acc;
  logic              par_ok_q;
  logic              wide_q;
  logic              we_q;
  logic [DATA_W-1:0] sh_q;
  logic              sh_msb;

  // decoded symbol events, brought out for the checker
  sym_e kind;
  logic is_dat, ob;
  logic ev_start, ev_busreset, ev_abort, ev_fail, ev_commit;
  logic addr_hit, addr_bcast;
  logic drive_slot, drive_val, par_match, in_msg, data_last;

  assign kind        = sym_e'(sym_kind);
  assign is_dat      = sym_valid && (kind == SYM_D0 || kind == SYM_D1);
  assign ob          = (kind == SYM_D1);
  assign ev_start    = sym_valid && (kind == SYM_START);
  assign ev_busreset = sym_valid && (kind == SYM_RESET);
  assign in_msg      = st inside {ST_DEV, ST_RW, ST_IADDR, ST_FETCH, ST_DATA, ST_PAR, ST_ACK};
  assign ev_abort    = ev_start && in_msg;
  assign ia_next     = {ia_q[IA_W-2:0], ob};
  assign data_last   = (cnt == CNT_W'(last_slot(wide_q, DATA_W, NARROW_W)));

  spb_addr_match #(.DEV_W(DEV_W)) u_match (
    .dev_field (dev_q),
    .my_dev    (my_dev),
    .hit       (addr_hit),
    .bcast     (addr_bcast)
  );

  // slots the slave owns: read data and parity, write acknowledge
  always_comb begin
    drive_slot = ((st == ST_DATA || st == ST_PAR) && rw_q) || (st == ST_ACK && !rw_q);
    unique case (st)
      ST_DATA: drive_val = sh_msb;
      ST_PAR:  drive_val = par_acc;
      default: drive_val = par_ok_q;
    endcase
  end

  assign par_match = (ob == par_acc);

  assign ev_fail =
      (drive_slot && sym_valid && ((is_dat && ob != drive_val) || kind == SYM_ATTN)) ||
      (st == ST_ACK && rw_q && sym_valid && (kind == SYM_ATTN || (is_dat && !ob)));

  assign ev_commit = is_dat && !rw_q &&
      ((st == ST_PAR && addr_bcast && par_match) ||
       (st == ST_ACK && par_ok_q && ob));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      dev_q    <= '0;
      rw_q     <= 1'b0;
      ia_q     <= '0;
      par_acc  <= 1'b0;
      par_ok_q <= 1'b0;
      wide_q   <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      we_q <= ev_commit;
      if (ev_busreset) begin
        st  <= ST_TRAIN;
        cnt <= '0;
      end else if (ev_start) begin
        st      <= ST_DEV;
        cnt     <= '0;
        par_acc <= 1'b0;
      end else if (ev_fail) begin
        st <= ST_IDLE;
      end else if (is_dat) begin
        unique case (st)
          ST_TRAIN: begin
            if (!ob) begin
              if (cnt == CNT_W'(TRAIN_LEN - 1)) st <= ST_IDLE;
              else cnt <= cnt + 1'b1;
            end
          end
          ST_DEV: begin
            dev_q   <= {dev_q[DEV_W-2:0], ob};
            par_acc <= fold_par(par_acc, ob);
            if (cnt == CNT_W'(DEV_W - 1)) begin
              st  <= ST_RW;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RW: begin
            rw_q    <= ob;
            par_acc <= fold_par(par_acc, ob);
            st      <= ST_IADDR;
            cnt     <= '0;
          end
          ST_IADDR: begin
            ia_q    <= ia_next;
            par_acc <= fold_par(par_acc, ob);
            if (cnt == CNT_W'(IA_W - 1)) begin
              wide_q <= WIDE_MAP[ia_next];
              cnt    <= '0;
              if (rw_q) st <= addr_hit ? ST_FETCH : ST_IGN;
              else      st <= (addr_hit || addr_bcast) ? ST_DATA : ST_IGN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            par_acc <= fold_par(par_acc, ob);
            if (data_last) begin
              st  <= ST_PAR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (rw_q) begin
              st <= ST_ACK;
            end else begin
              par_ok_q <= par_match;
              st       <= addr_bcast ? ST_IGN : ST_ACK;
            end
          end
          ST_ACK:  st <= ST_IDLE;
          default: ;
        endcase
      end else if (st == ST_FETCH) begin
        st <= ST_DATA;
      end
    end
  end

  spb_shifter #(.W(DATA_W), .NW(NARROW_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_start),
    .load     (st == ST_FETCH),
    .load_val (reg_rdata),
    .shift    (is_dat && st == ST_DATA),
    .in_bit   (ob),
    .wide     (wide_q),
    .q        (sh_q),
    .msb      (sh_msb)
  );

  spb_attn_ctl u_attn (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (ev_fail),
    .drop     (ev_busreset),
    .bus_idle (bus_idle),
    .ber      (ber),
    .pend     (attn_pend),
    .fire     (tx_attn)
  );

  assign tx_en     = drive_slot;
  assign tx_bit    = drive_slot && drive_val;
  assign reg_addr  = ia_q;
  assign reg_wdata = wide_q ? sh_q : {{PAD{1'b0}}, sh_q[NARROW_W-1:0]};
  assign reg_we    = we_q;
  assign reg_re    = (st == ST_FETCH);

endmodule

// File: rtl/spb_slave_engine_chk.sv
module spb_slave_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_idle,
  input logic tx_en,
  input logic tx_attn,
  input logic reg_we,
  input logic reg_re,
  input logic ber,
  input logic attn_pend,
  input logic ev_fail,
  input logic ev_abort,
  input logic ev_busreset,
  input logic addr_hit,
  input logic addr_bcast
);
  // R12: attention goes out only after an idle bus was seen
  a_r12_attn_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_attn |-> $past(bus_idle));

  // R12: attention is a single-cycle pulse that empties the pending flag
  a_r12_attn_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_attn |-> !attn_pend);

  // R4: the write strobe lasts one cycle
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6: a read strobe is followed by the slave taking the first data slot
  a_r6_re_then_drive: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> (tx_en && !reg_re));

  // R6: read and write strobes never overlap
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_re && reg_we));

  // R8: broadcast messages are never driven
  a_r8_bcast_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !addr_bcast);

  // R9: only an own-address message is driven
  a_r9_drive_own: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> addr_hit);

  // R7: a failure raises the error flag and an attention request
  a_r7_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> (ber && attn_pend));

  // R10: abandoning a message leaves the error flag untouched
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> $stable(ber));

  // R11: a bus reset leaves nothing driven and nothing pending
  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busreset |=> (!tx_en && !attn_pend));
endmodule

bind spb_slave_engine spb_slave_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_idle    (bus_idle),
  .tx_en       (tx_en),
  .tx_attn     (tx_attn),
  .reg_we      (reg_we),
  .reg_re      (reg_re),
  .ber         (ber),
  .attn_pend   (attn_pend),
  .ev_fail     (ev_fail),
  .ev_abort    (ev_abort),
  .ev_busreset (ev_busreset),
  .addr_hit    (addr_hit),
  .addr_bcast  (addr_bcast)
);

// File: tb/sim_spb_slave_engine.sv
module sim_spb_slave_engine;
  localparam int          CLK_P = 10;
  localparam logic [63:0] WMAP  = 64'hF0F0_0000_3C00_00A6;
  localparam logic [2:0]  ME    = 3'd5;
  localparam int K_D0 = 0, K_D1 = 1, K_ST = 2, K_AT = 3, K_RS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0;
  logic [2:0]  sym_kind = 3'd0;
  logic        bus_idle = 1'b0;
  logic        tx_en, tx_bit, tx_attn, reg_we, reg_re, ber, attn_pend;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  spb_slave_engine #(.WIDE_MAP(WMAP)) u0 (
    .clk(clk), .rst_n(rst_n), .my_dev(ME), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .bus_idle(bus_idle), .tx_en(tx_en), .tx_bit(tx_bit), .tx_attn(tx_attn),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .ber(ber), .attn_pend(attn_pend)
  );

  always #(CLK_P/2) clk = ~clk;

  // register file model and strobe counters
  logic [15:0] mem [64];
  int we_cnt, re_cnt, attn_cnt;
  logic [5:0]  we_addr;
  logic [15:0] we_data;
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'hA5C3 ^ 16'(i * 291);
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_cnt  <= we_cnt + 1;
        we_addr <= reg_addr;
        we_data <= reg_wdata;
      end
      if (reg_re)  re_cnt   <= re_cnt + 1;
      if (tx_attn) attn_cnt <= attn_cnt + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_wide(input logic [5:0] ia);
    return WMAP[ia];
  endfunction

  task automatic sym(input int k);
    @(negedge clk);
    sym_kind  = 3'(k);
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sym(v[i] ? K_D1 : K_D0);
  endtask

  task automatic header(input logic [2:0] dev, input logic rw, input logic [5:0] ia);
    sym(K_ST);
    send_bits({13'd0, dev}, 3);
    sym(rw ? K_D1 : K_D0);
    send_bits({10'd0, ia}, 6);
  endtask

  // force_ack < 0: echo the slave; gap_at >= 0: long gap plus attention after that data bit
  task automatic write_msg(input logic [2:0] dev, input logic [5:0] ia, input logic [15:0] d,
                           input logic bad, input int force_ack, input int gap_at,
                           output logic ack_en, output logic ack_bit);
    int n;
    logic p;
    n = is_wide(ia) ? 16 : 8;
    header(dev, 1'b0, ia);
    for (int i = n - 1; i >= 0; i--) begin
      sym(d[i] ? K_D1 : K_D0);
      if (i == gap_at) begin
        repeat (3000) @(negedge clk);
        sym(K_AT);
      end
    end
    p = (^dev) ^ (^ia) ^ (n == 16 ? ^d : ^d[7:0]) ^ bad;
    sym(p ? K_D1 : K_D0);
    ack_en  = tx_en;
    ack_bit = tx_bit;
    if (force_ack >= 0) sym(force_ack);
    else sym((tx_en && tx_bit) ? K_D1 : K_D0);
  endtask

  task automatic read_msg(input logic [2:0] dev, input logic [5:0] ia, input int disrupt,
                          input int ack_k, output logic [15:0] val, output logic pb,
                          output int drv);
    int n;
    n = is_wide(ia) ? 16 : 8;
    val = '0;
    drv = 0;
    header(dev, 1'b1, ia);
    for (int i = 0; i < n; i++) begin
      if (tx_en) drv++;
      val = {val[14:0], tx_bit};
      if (i == disrupt) sym(K_AT);
      else sym((tx_en && tx_bit) ? K_D1 : K_D0);
    end
    if (tx_en) drv++;
    pb = tx_bit;
    sym((tx_en && tx_bit) ? K_D1 : K_D0);
    sym(ack_k);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sym_valid = 1'b0; bus_idle = 1'b0;
    we_cnt = 0; re_cnt = 0; attn_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13 watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ae, ab, pb, ep;
    logic [15:0] v, ev, d;
    int drv, w0, r0, n;

    do_reset();
    // R1 reset state
    chk("R1 tx_en", tx_en, 0);
    chk("R1 tx_attn", tx_attn, 0);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_re", reg_re, 0);
    chk("R1 ber", ber, 0);
    chk("R1 attn_pend", attn_pend, 0);

    // R2 R3 R4: write sweep over every register of the own device
    for (int ia = 0; ia < 64; ia++) begin
      d  = 16'h3A5C ^ 16'(ia * 4369);
      w0 = we_cnt;
      write_msg(ME, 6'(ia), d, 1'b0, -1, -1, ae, ab);
      chk("R4 ack driven", {ae, ab}, 2'b11);
      chk("R4 one write", we_cnt - w0, 1);
      chk("R2 write addr", we_addr, ia);
      chk("R3 write data", we_data, is_wide(6'(ia)) ? d : {8'd0, d[7:0]});
    end

    // R6 R3: read sweep, value and parity computed from the register model
    for (int ia = 0; ia < 64; ia++) begin
      n  = is_wide(6'(ia)) ? 16 : 8;
      ev = (n == 16) ? mem[ia] : {8'd0, mem[ia][7:0]};
      ep = (^ME) ^ 1'b1 ^ (^6'(ia)) ^ (^ev);
      r0 = re_cnt;
      read_msg(ME, 6'(ia), -1, K_D1, v, pb, drv);
      chk("R6 read value", v, ev);
      chk("R6 parity", pb, ep);
      chk("R6 slots driven", drv, n + 1);
      chk("R6 one read", re_cnt - r0, 1);
    end
    chk("R6 no error", ber, 0);

    // R9 foreign devices
    for (int dv = 1; dv < 8; dv++) begin
      if (dv == ME) continue;
      w0 = we_cnt; r0 = re_cnt;
      write_msg(3'(dv), 6'(dv * 3), 16'h1234, 1'b0, -1, -1, ae, ab);
      chk("R9 foreign write no ack", ae, 0);
      read_msg(3'(dv), 6'(dv * 5), -1, K_D1, v, pb, drv);
      chk("R9 foreign read no drive", drv, 0);
      chk("R9 no strobes", (we_cnt - w0) + (re_cnt - r0), 0);
    end

    // R8 broadcast
    w0 = we_cnt;
    write_msg(3'd0, 6'd1, 16'hBEEF, 1'b0, -1, -1, ae, ab);
    chk("R8 broadcast no ack", ae, 0);
    chk("R8 broadcast committed", we_cnt - w0, 1);
    chk("R8 broadcast data", we_data, is_wide(6'd1) ? 16'hBEEF : 16'h00EF);
    w0 = we_cnt;
    write_msg(3'd0, 6'd2, 16'h4321, 1'b1, -1, -1, ae, ab);
    chk("R8 broadcast bad parity dropped", we_cnt - w0, 0);
    r0 = re_cnt;
    read_msg(3'd0, 6'd3, -1, K_D1, v, pb, drv);
    chk("R8 broadcast read silent", drv, 0);
    chk("R8 broadcast read no strobe", re_cnt - r0, 0);

    // R5 bad parity to own device
    w0 = we_cnt;
    write_msg(ME, 6'd4, 16'h00C3, 1'b1, -1, -1, ae, ab);
    chk("R5 nack driven", {ae, ab}, 2'b10);
    chk("R5 no write", we_cnt - w0, 0);
    chk("R5 no error", ber, 0);

    // R7 R12: read with negative acknowledge, attention waits for idle
    read_msg(ME, 6'd5, -1, K_D0, v, pb, drv);
    chk("R7 ber after nack", ber, 1);
    chk("R7 attention pending", attn_pend, 1);
    repeat (20) @(negedge clk);
    chk("R12 no attention while busy", attn_cnt, 0);
    bus_idle = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 one attention", attn_cnt, 1);
    chk("R12 pending cleared", attn_pend, 0);
    repeat (10) @(negedge clk);
    chk("R12 still one attention", attn_cnt, 1);
    bus_idle = 1'b0;

    // R7 disrupted read data slot
    do_reset();
    read_msg(ME, 6'd7, 3, K_D1, v, pb, drv);
    chk("R7 ber after disrupted read", ber, 1);
    chk("R7 pending after disrupted read", attn_pend, 1);

    // R7 disrupted write acknowledge
    do_reset();
    w0 = we_cnt;
    write_msg(ME, 6'd9, 16'h0055, 1'b0, K_D0, -1, ae, ab);
    chk("R7 ack disrupted no write", we_cnt - w0, 0);
    chk("R7 ber after ack disruption", ber, 1);

    // R10 start mid-message
    do_reset();
    sym(K_ST); send_bits({13'd0, ME}, 3); sym(K_D0); send_bits(16'h0005, 3);
    w0 = we_cnt;
    write_msg(ME, 6'd2, 16'h5A5A, 1'b0, -1, -1, ae, ab);
    chk("R10 new message committed", we_cnt - w0, 1);
    chk("R10 new message addr", we_addr, 2);
    header(ME, 1'b1, 6'd1);
    sym(K_D1); sym(K_D0);
    write_msg(ME, 6'd6, 16'h0099, 1'b0, -1, -1, ae, ab);
    chk("R10 after read abort", we_addr, 6);
    chk("R10 no error", ber, 0);
    chk("R10 no attention", attn_pend, 0);

    // R11 bus reset, training bits and pending attention
    read_msg(ME, 6'd5, -1, K_D0, v, pb, drv);
    chk("R11 setup pending", attn_pend, 1);
    w0 = we_cnt; r0 = re_cnt;
    sym(K_ST); send_bits({13'd0, ME}, 3);
    sym(K_RS);
    chk("R11 reset clears pending", attn_pend, 0);
    for (int i = 0; i < 8; i++) sym(K_D0);
    send_bits({6'd0, ME, 1'b1, 6'd4}, 10);
    chk("R11 training not decoded", (we_cnt - w0) + (re_cnt - r0), 0);
    chk("R11 nothing driven", tx_en, 0);
    write_msg(ME, 6'd11, 16'h0077, 1'b0, -1, -1, ae, ab);
    chk("R11 message after training", we_addr, 11);

    // R13 long gap and attention inside a write
    w0 = we_cnt;
    write_msg(ME, 6'd13, 16'hC0DE, 1'b0, -1, 4, ae, ab);
    chk("R13 committed after gap", we_cnt - w0, 1);
    chk("R13 data after gap", we_data, is_wide(6'd13) ? 16'hC0DE : 16'h00DE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule